// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the integer execute stage of a 32-bit processor core. The decoder gives it an operation code, a sub-code, two operands (operand B may already be a sign- or zero-extended immediate) and the current carry, compare-flag and overflow-exception-enable bits, together with a one-cycle start strobe. The block returns the result, a result-write enable, write enables and values for the carry, overflow and compare flags, and a range-exception request. All of these are valid for one cycle while `done_o` is high.

Most operations finish in the cycle after the accepting clock edge. Signed and unsigned division use a restoring divider that produces one quotient bit per cycle. While it runs, `busy_o` is high and further start strobes are ignored. Carry and overflow mean different things for different operations. For add and subtract they are the unsigned carry or borrow and the signed overflow. For multiply, carry is unsigned overflow. For divide, carry reports a zero divisor. A range exception is requested from these flags when exceptions are enabled. For immediate compares the decoder sign-extends the 16-bit immediate before it reaches operand B, and it does this for the unsigned compares as well.

Top module: `int_exec_unit`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `result_o`, every write enable, every flag output and `range_exc_o` are 0.
- R2: `op_i` codes are: 0 add, 1 add-with-carry, 2 subtract, 3 and, 4 or, 5 xor, 6 signed multiply, 7 unsigned multiply, 8 signed divide, 9 unsigned divide, 10 shift/rotate, 11 extend, 12 find-first-one, 13 find-last-one, 14 conditional move, 15 compare. A start accepted when `busy_o` is low, for any code other than 8 or 9, gives a one-cycle `done_o` in the cycle after the accepting edge, with all outputs valid in that cycle.
- R3: Add, add-with-carry and subtract write the result. They set carry to the unsigned carry-out (borrow for subtract, meaning A < B unsigned) and overflow to the signed overflow. Add-with-carry also adds `carry_i`.
- R4: Signed multiply writes the low 32 product bits. It sets overflow when the signed product does not fit in 32 bits, and carry when the unsigned product of the raw operands does not fit. Unsigned multiply sets carry the same way and writes overflow as 0.
- R5: Signed divide truncates toward zero, and 0x80000000 / 0xFFFFFFFF returns 0x80000000. Unsigned divide uses unsigned operands. A division raises `busy_o` from the cycle after the accepting edge, and `done_o` comes DW+1 cycles after the cycle in which a single-cycle operation would report. Start strobes seen while `busy_o` is high are ignored.
- R6: A division by zero writes carry as 1, leaves the result unwritten (`wr_en_o` = 0) and writes overflow as 0. A nonzero divisor writes carry as 0 and overflow as 0.
- R7: `range_exc_o` is raised with `done_o` when `ove_i` was set at the start and the written overflow is 1. For division, the written carry is used in place of overflow.
- R8: A compare writes only the compare flag (`flag_we_o` = 1; `wr_en_o`, `carry_we_o`, `ovf_we_o` = 0). Its `sub_i` sub-codes are 0x00 equal, 0x01 not equal, 0x02/0x03/0x04/0x05 unsigned greater, greater-or-equal, less, less-or-equal, and 0x0A/0x0B/0x0C/0x0D the same four relations signed. Any other sub-code writes the flag as 0.
- R9: Shift uses `sub_i[1:0]`: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right. The amount is the low 5 bits of operand B.
- R10: Extend uses `sub_i[1:0]`: 0 sign-extends bits 15:0, 1 sign-extends bits 7:0, 2 zero-extends bits 15:0, 3 zero-extends bits 7:0 of operand A.
- R11: Find-first-one returns the 1-based position of the lowest set bit of A. Find-last-one returns the 1-based position of the highest set bit. Both return 0 when A is 0.
- R12: Conditional move returns A when `flag_i` is 1 and B otherwise.
- R13: And, or, xor, shift, extend, find and conditional move write only the result, with every flag write enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one operation |
| op_i | input | 4 | Operation code (R2) |
| sub_i | input | 5 | Sub-code for shift, extend and compare |
| opa_i | input | DW | Operand A |
| opb_i | input | DW | Operand B or extended immediate |
| carry_i | input | 1 | Current carry bit |
| flag_i | input | 1 | Current compare flag |
| ove_i | input | 1 | Overflow exception enable |
| busy_o | output | 1 | Divider running |
| done_o | output | 1 | Outputs valid this cycle |
| result_o | output | DW | Result value |
| wr_en_o | output | 1 | Result write enable |
| carry_o | output | 1 | New carry value |
| carry_we_o | output | 1 | Carry write enable |
| ovf_o | output | 1 | New overflow value |
| ovf_we_o | output | 1 | Overflow write enable |
| flag_o | output | 1 | New compare flag |
| flag_we_o | output | 1 | Compare flag write enable |
| range_exc_o | output | 1 | Range exception request |

## Verification
The interesting overlap is a start strobe that arrives while the divider is running, in the same cycle that a single-cycle operation could otherwise begin. The bench starts a division and, one cycle later, raises start with an add. It expects the division result at the division's own completion cycle, no early `done_o`, and no second `done_o` afterwards. A second overlap is the range exception that falls in the same cycle as a divide-by-zero report. It is provoked with a zero divisor and exceptions enabled, and judged against the model's carry-driven exception bit.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDC = 4'd1,
      OP_SUB  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_MUL  = 4'd6,
      OP_MULU = 4'd7,
      OP_DIV  = 4'd8,
      OP_DIVU = 4'd9,
      OP_SHFT = 4'd10,
      OP_EXT  = 4'd11,
      OP_FF1  = 4'd12,
      OP_FL1  = 4'd13,
      OP_CMOV = 4'd14,
      OP_CMP  = 4'd15
   } op_e;

   // compare sub-codes
   localparam logic [4:0] CMP_EQ  = 5'h00;
   localparam logic [4:0] CMP_NE  = 5'h01;
   localparam logic [4:0] CMP_GTU = 5'h02;
   localparam logic [4:0] CMP_GEU = 5'h03;
   localparam logic [4:0] CMP_LTU = 5'h04;
   localparam logic [4:0] CMP_LEU = 5'h05;
   localparam logic [4:0] CMP_GTS = 5'h0A;
   localparam logic [4:0] CMP_GES = 5'h0B;
   localparam logic [4:0] CMP_LTS = 5'h0C;
   localparam logic [4:0] CMP_LES = 5'h0D;

   // shift and extend sub-codes
   localparam logic [1:0] SH_LL = 2'd0;
   localparam logic [1:0] SH_RL = 2'd1;
   localparam logic [1:0] SH_RA = 2'd2;
   localparam logic [1:0] SH_RR = 2'd3;
   localparam logic [1:0] EX_SH = 2'd0;
   localparam logic [1:0] EX_SB = 2'd1;
   localparam logic [1:0] EX_ZH = 2'd2;
   localparam logic [1:0] EX_ZB = 2'd3;

   typedef struct packed {
      logic res_we;
      logic cy_we;
      logic cy;
      logic ov_we;
      logic ov;
      logic f_we;
      logic f;
   } wb_flags_t;

endpackage

// File: rtl/iexu_mul.sv
module iexu_mul #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   output logic [DW-1:0] lo_o,
   output logic          sov_o,
   output logic          uov_o
);
   localparam int MSB = DW - 1;

   logic [2*DW-1:0] uprod;
   logic [DW-1:0]   u_hi;
   logic [DW-1:0]   s_hi;

   always_comb begin
      uprod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
      u_hi  = uprod[2*DW-1:DW];
      // signed high word from the unsigned one
      s_hi  = u_hi - (a_i[MSB] ? b_i : '0) - (b_i[MSB] ? a_i : '0);
   end

   assign lo_o  = uprod[DW-1:0];
   assign uov_o = |u_hi;
   assign sov_o = (s_hi != {DW{uprod[MSB]}});

endmodule

// File: rtl/iexu_bitscan.sv
module iexu_bitscan #(
   parameter int DW = 32,
   parameter int IW = $clog2(DW + 1)
) (
   input  logic [DW-1:0] a_i,
   output logic [IW-1:0] low_o,
   output logic [IW-1:0] high_o
);

   always_comb begin
      low_o = '0;
      for (int i = DW - 1; i >= 0; i--) begin
         if (a_i[i]) low_o = IW'(i + 1);
      end
   end

   always_comb begin
      high_o = '0;
      for (int i = 0; i < DW; i++) begin
         if (a_i[i]) high_o = IW'(i + 1);
      end
   end

endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
   import iexu_pkg::*;
#(
   parameter int DW = 32,
   parameter int IW = $clog2(DW + 1)
) (
   input  op_e           op_i,
   input  logic [4:0]    sub_i,
   input  logic [DW-1:0] a_i,
   input  logic [DW-1:0] b_i,
   input  logic          cin_i,
   input  logic          fin_i,
   input  logic [DW-1:0] mul_lo_i,
   input  logic          mul_sov_i,
   input  logic          mul_uov_i,
   input  logic [IW-1:0] ff1_i,
   input  logic [IW-1:0] fl1_i,
   output logic [DW-1:0] res_o,
   output wb_flags_t     wb_o
);
   localparam int MSB = DW - 1;
   localparam int SW  = $clog2(DW);

   logic [DW:0]     sum;
   logic [DW:0]     dif;
   logic [SW-1:0]   amt;
   logic [2*DW-1:0] rot;
   logic [DW-1:0]   sh_res;
   logic [DW-1:0]   ex_res;
   logic            lt_u, lt_s, eq;
   logic            cmp_res;

   always_comb begin
      sum = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'((op_i == OP_ADDC) & cin_i);
      dif = {1'b0, a_i} - {1'b0, b_i};
   end

   always_comb begin
      amt = b_i[SW-1:0];
      rot = {a_i, a_i} >> amt;
      unique case (sub_i[1:0])
         SH_LL:   sh_res = a_i << amt;
         SH_RL:   sh_res = a_i >> amt;
         SH_RA:   sh_res = $signed(a_i) >>> amt;
         default: sh_res = rot[DW-1:0];
      endcase
   end

   always_comb begin
      unique case (sub_i[1:0])
         EX_SH:   ex_res = {{(DW-16){a_i[15]}}, a_i[15:0]};
         EX_SB:   ex_res = {{(DW-8){a_i[7]}}, a_i[7:0]};
         EX_ZH:   ex_res = {{(DW-16){1'b0}}, a_i[15:0]};
         default: ex_res = {{(DW-8){1'b0}}, a_i[7:0]};
      endcase
   end

   always_comb begin
      eq   = (a_i == b_i);
      lt_u = (a_i < b_i);
      lt_s = ($signed(a_i) < $signed(b_i));
      case (sub_i)
         CMP_EQ:  cmp_res = eq;
         CMP_NE:  cmp_res = !eq;
         CMP_GTU: cmp_res = !lt_u && !eq;
         CMP_GEU: cmp_res = !lt_u;
         CMP_LTU: cmp_res = lt_u;
         CMP_LEU: cmp_res = lt_u || eq;
         CMP_GTS: cmp_res = !lt_s && !eq;
         CMP_GES: cmp_res = !lt_s;
         CMP_LTS: cmp_res = lt_s;
         CMP_LES: cmp_res = lt_s || eq;
         default: cmp_res = 1'b0;
      endcase
   end

   always_comb begin
      res_o = '0;
      wb_o  = '0;
      case (op_i)
         OP_ADD, OP_ADDC: begin
            res_o       = sum[DW-1:0];
            wb_o.res_we = 1'b1;
            wb_o.cy_we  = 1'b1;
            wb_o.cy     = sum[DW];
            wb_o.ov_we  = 1'b1;
            wb_o.ov     = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);
         end
         OP_SUB: begin
            res_o       = dif[DW-1:0];
            wb_o.res_we = 1'b1;
            wb_o.cy_we  = 1'b1;
            wb_o.cy     = dif[DW];
            wb_o.ov_we  = 1'b1;
            wb_o.ov     = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != a_i[MSB]);
         end
         OP_AND: begin res_o = a_i & b_i; wb_o.res_we = 1'b1; end
         OP_OR:  begin res_o = a_i | b_i; wb_o.res_we = 1'b1; end
         OP_XOR: begin res_o = a_i ^ b_i; wb_o.res_we = 1'b1; end
         OP_MUL, OP_MULU: begin
            res_o       = mul_lo_i;
            wb_o.res_we = 1'b1;
            wb_o.cy_we  = 1'b1;
            wb_o.cy     = mul_uov_i;
            wb_o.ov_we  = 1'b1;
            wb_o.ov     = (op_i == OP_MUL) & mul_sov_i;
         end
         OP_SHFT: begin res_o = sh_res;          wb_o.res_we = 1'b1; end
         OP_EXT:  begin res_o = ex_res;          wb_o.res_we = 1'b1; end
         OP_FF1:  begin res_o = DW'(ff1_i);      wb_o.res_we = 1'b1; end
         OP_FL1:  begin res_o = DW'(fl1_i);      wb_o.res_we = 1'b1; end
         OP_CMOV: begin res_o = fin_i ? a_i : b_i; wb_o.res_we = 1'b1; end
         OP_CMP: begin
            wb_o.f_we = 1'b1;
            wb_o.f    = cmp_res;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/iexu_div.sv
module iexu_div #(
   parameter int DW = 32,
   parameter int CW = $clog2(DW + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          signed_i,
   input  logic [DW-1:0] num_i,
   input  logic [DW-1:0] den_i,
   output logic          busy_o,
   output logic          fin_o,
   output logic          dz_o,
   output logic [DW-1:0] quo_o
);
   localparam int MSB = DW - 1;

   logic          active;
   logic [CW-1:0] cnt;
   logic [DW:0]   rem;
   logic [DW-1:0] quo;
   logic [DW-1:0] den;
   logic          neg;
   logic          dz;
   logic [DW-1:0] num_mag, den_mag;
   logic [DW:0]   shifted;

   always_comb begin
      num_mag = (signed_i && num_i[MSB]) ? (~num_i + DW'(1)) : num_i;
      den_mag = (signed_i && den_i[MSB]) ? (~den_i + DW'(1)) : den_i;
      shifted = {rem[DW-1:0], quo[MSB]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         rem    <= '0;
         quo    <= '0;
         den    <= '0;
         neg    <= 1'b0;
         dz     <= 1'b0;
      end else if (start_i) begin
         active <= 1'b1;
         cnt    <= CW'(DW);
         rem    <= '0;
         quo    <= num_mag;
         den    <= den_mag;
         neg    <= signed_i && (num_i[MSB] ^ den_i[MSB]);
         dz     <= (den_i == '0);
      end else if (active) begin
         if (cnt != '0) begin
            cnt <= cnt - CW'(1);
            if (shifted >= {1'b0, den}) begin
               rem <= shifted - {1'b0, den};
               quo <= {quo[DW-2:0], 1'b1};
            end else begin
               rem <= shifted;
               quo <= {quo[DW-2:0], 1'b0};
            end
         end else begin
            active <= 1'b0;
         end
      end
   end

   assign busy_o = active;
   assign fin_o  = active && (cnt == '0);
   assign dz_o   = dz;
   assign quo_o  = neg ? (~quo + DW'(1)) : quo;

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import iexu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [3:0]    op_i,
   input  logic [4:0]    sub_i,
   input  logic [DW-1:0] opa_i,
   input  logic [DW-1:0] opb_i,
   input  logic          carry_i,
   input  logic          flag_i,
   input  logic          ove_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] result_o,
   output logic          wr_en_o,
   output logic          carry_o,
   output logic          carry_we_o,
   output logic          ovf_o,
   output logic          ovf_we_o,
   output logic          flag_o,
   output logic          flag_we_o,
   output logic          range_exc_o
);
   localparam int IW = $clog2(DW + 1);

   generate
      if (DW < 16 || (DW & (DW - 1)) != 0) begin : g_bad_width
         $error("int_exec_unit: DW must be a power of two of at least 16");
      end
   endgenerate

   op_e           op;
   logic          is_div, accept, div_start;
   logic [DW-1:0] mul_lo;
   logic          mul_sov, mul_uov;
   logic [IW-1:0] ff1_idx, fl1_idx;
   logic [DW-1:0] alu_res;
   wb_flags_t     alu_wb;
   logic          div_busy, div_fin, div_dz;
   logic [DW-1:0] div_quo;
   logic          div_ove;

   wb_flags_t     out_wb;
   logic [DW-1:0] out_res;
   logic          out_done, out_exc;

   assign op        = op_e'(op_i);
   assign is_div    = (op == OP_DIV) || (op == OP_DIVU);
   assign accept    = start_i && !div_busy;
   assign div_start = accept && is_div;

   iexu_mul #(.DW(DW)) u_mul (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .lo_o  (mul_lo),
      .sov_o (mul_sov),
      .uov_o (mul_uov)
   );

   iexu_bitscan #(.DW(DW), .IW(IW)) u_scan (
      .a_i    (opa_i),
      .low_o  (ff1_idx),
      .high_o (fl1_idx)
   );

   iexu_alu #(.DW(DW), .IW(IW)) u_alu (
      .op_i      (op),
      .sub_i     (sub_i),
      .a_i       (opa_i),
      .b_i       (opb_i),
      .cin_i     (carry_i),
      .fin_i     (flag_i),
      .mul_lo_i  (mul_lo),
      .mul_sov_i (mul_sov),
      .mul_uov_i (mul_uov),
      .ff1_i     (ff1_idx),
      .fl1_i     (fl1_idx),
      .res_o     (alu_res),
      .wb_o      (alu_wb)
   );

   iexu_div #(.DW(DW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (div_start),
      .signed_i (op == OP_DIV),
      .num_i    (opa_i),
      .den_i    (opb_i),
      .busy_o   (div_busy),
      .fin_o    (div_fin),
      .dz_o     (div_dz),
      .quo_o    (div_quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_ove <= 1'b0;
      else if (div_start) div_ove <= ove_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_done <= 1'b0;
         out_res  <= '0;
         out_wb   <= '0;
         out_exc  <= 1'b0;
      end else if (div_fin) begin
         out_done      <= 1'b1;
         out_res       <= div_quo;
         out_wb        <= '0;
         out_wb.res_we <= !div_dz;
         out_wb.cy_we  <= 1'b1;
         out_wb.cy     <= div_dz;
         out_wb.ov_we  <= 1'b1;
         out_exc       <= div_dz & div_ove;
      end else if (accept && !is_div) begin
         out_done <= 1'b1;
         out_res  <= alu_res;
         out_wb   <= alu_wb;
         out_exc  <= alu_wb.ov & ove_i;
      end else begin
         out_done <= 1'b0;
         out_wb   <= '0;
         out_exc  <= 1'b0;
      end
   end

   assign busy_o      = div_busy;
   assign done_o      = out_done;
   assign result_o    = out_res;
   assign wr_en_o     = out_wb.res_we;
   assign carry_o     = out_wb.cy;
   assign carry_we_o  = out_wb.cy_we;
   assign ovf_o       = out_wb.ov;
   assign ovf_we_o    = out_wb.ov_we;
   assign flag_o      = out_wb.f;
   assign flag_we_o   = out_wb.f_we;
   assign range_exc_o = out_exc;

endmodule

// File: rtl/iexu_chk.sv
module iexu_chk
   import iexu_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic [3:0] op_i,
   input logic       busy_o,
   input logic       done_o,
   input logic       wr_en_o,
   input logic       carry_o,
   input logic       carry_we_o,
   input logic       ovf_o,
   input logic       ovf_we_o,
   input logic       flag_we_o,
   input logic       range_exc_o
);

   // R2
   single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && op_i != OP_DIV && op_i != OP_DIVU) |=> done_o);

   // R5
   div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && (op_i == OP_DIV || op_i == OP_DIVU)) |=> (busy_o && !done_o));

   // R6
   div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && carry_we_o && !wr_en_o) |-> (carry_o && ovf_we_o && !ovf_o));

   // R7
   range_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      range_exc_o |-> (done_o && ((ovf_we_o && ovf_o) || (carry_we_o && carry_o && !wr_en_o))));

   // R8
   cmp_only_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we_o |-> (done_o && !wr_en_o && !carry_we_o && !ovf_we_o));

   // R2
   wr_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> done_o);

endmodule

bind int_exec_unit iexu_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .op_i        (op_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .wr_en_o     (wr_en_o),
   .carry_o     (carry_o),
   .carry_we_o  (carry_we_o),
   .ovf_o       (ovf_o),
   .ovf_we_o    (ovf_we_o),
   .flag_we_o   (flag_we_o),
   .range_exc_o (range_exc_o)
);

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;
   localparam int DW      = 32;
   localparam int DIV_LAT = DW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    op = '0;
   logic [4:0]    sub = '0;
   logic [31:0]   a = '0, b = '0;
   logic          cin = 1'b0, fin = 1'b0, ove = 1'b0;
   logic          busy_o, done_o, wr_en_o, carry_o, carry_we_o;
   logic          ovf_o, ovf_we_o, flag_o, flag_we_o, range_exc_o;
   logic [31:0]   result_o;

   int checks = 0;
   int fails  = 0;
   bit ended  = 1'b0;

   always #4 clk = ~clk;

   int_exec_unit #(.DW(DW)) u_int_exec_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .sub_i(sub),
      .opa_i(a), .opb_i(b), .carry_i(cin), .flag_i(fin), .ove_i(ove),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o),
      .carry_o(carry_o), .carry_we_o(carry_we_o), .ovf_o(ovf_o), .ovf_we_o(ovf_we_o),
      .flag_o(flag_o), .flag_we_o(flag_we_o), .range_exc_o(range_exc_o)
   );

   // layout: wr, cy_we, cy, ov_we, ov, f_we, f, exc, result[31:0]
   function automatic logic [39:0] observed();
      return {wr_en_o, carry_we_o, carry_o, ovf_we_o, ovf_o,
              flag_we_o, flag_o, range_exc_o, result_o};
   endfunction

   function automatic bit out_of_range(longint v);
      return (v > 64'sd2147483647) || (v < -64'sd2147483648);
   endfunction

   function automatic logic [39:0] model(int o, logic [4:0] s, logic [31:0] x, logic [31:0] y,
                                         logic c, logic f, logic e);
      logic wr = 0, cyw = 0, cy = 0, ovw = 0, ov = 0, fw = 0, fl = 0, ex;
      logic [31:0] r = '0;
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(y));
      longint unsigned ux = {32'd0, x};
      longint unsigned uy = {32'd0, y};
      longint ss;
      longint unsigned pu;
      int amt = int'(y[4:0]);
      case (o)
         0, 1: begin
            pu = ux + uy + ((o == 1 && c) ? 64'd1 : 64'd0);
            ss = sx + sy + ((o == 1 && c) ? 64'sd1 : 64'sd0);
            r = pu[31:0]; cy = pu[32]; ov = out_of_range(ss);
            wr = 1; cyw = 1; ovw = 1;
         end
         2: begin
            r = x - y; cy = (x < y); ov = out_of_range(sx - sy);
            wr = 1; cyw = 1; ovw = 1;
         end
         3: begin r = x & y; wr = 1; end
         4: begin r = x | y; wr = 1; end
         5: begin r = x ^ y; wr = 1; end
         6, 7: begin
            pu = ux * uy; r = pu[31:0]; cy = (pu[63:32] != 0);
            ov = (o == 6) ? out_of_range(sx * sy) : 1'b0;
            wr = 1; cyw = 1; ovw = 1;
         end
         8, 9: begin
            cyw = 1; ovw = 1;
            if (y == 0) cy = 1;
            else begin
               wr = 1;
               r = (o == 8) ? 32'(sx / sy) : (x / y);
            end
         end
         10: begin
            wr = 1;
            case (s[1:0])
               2'd0: r = x << amt;
               2'd1: r = x >> amt;
               2'd2: r = $signed(x) >>> amt;
               default: begin
                  r = x;
                  for (int i = 0; i < amt; i++) r = {r[0], r[31:1]};
               end
            endcase
         end
         11: begin
            wr = 1;
            case (s[1:0])
               2'd0: r = {{16{x[15]}}, x[15:0]};
               2'd1: r = {{24{x[7]}}, x[7:0]};
               2'd2: r = {16'd0, x[15:0]};
               default: r = {24'd0, x[7:0]};
            endcase
         end
         12: begin
            wr = 1;
            for (int i = 31; i >= 0; i--) if (x[i]) r = 32'(i + 1);
         end
         13: begin
            wr = 1;
            for (int i = 0; i < 32; i++) if (x[i]) r = 32'(i + 1);
         end
         14: begin wr = 1; r = f ? x : y; end
         default: begin
            fw = 1;
            case (s)
               5'h00: fl = (x == y);
               5'h01: fl = (x != y);
               5'h02: fl = (x > y);
               5'h03: fl = (x >= y);
               5'h04: fl = (x < y);
               5'h05: fl = (x <= y);
               5'h0A: fl = (sx > sy);
               5'h0B: fl = (sx >= sy);
               5'h0C: fl = (sx < sy);
               5'h0D: fl = (sx <= sy);
               default: fl = 0;
            endcase
         end
      endcase
      ex = (o == 8 || o == 9) ? (cy & e) : (ov & e);
      return {wr, cyw, cy, ovw, ov, fw, fl, ex, r};
   endfunction

   task automatic run_op(string req, int o, logic [4:0] s, logic [31:0] x, logic [31:0] y,
                         logic c, logic f, logic e);
      logic [39:0] expv, actv;
      int lat;
      bit early = 0;
      expv = model(o, s, x, y, c, f, e);
      lat  = (o == 8 || o == 9) ? DIV_LAT : 1;
      op = 4'(o); sub = s; a = x; b = y; cin = c; fin = f; ove = e; start = 1'b1;
      for (int k = 1; k <= lat; k++) begin
         @(negedge clk);
         if (k == 1) start = 1'b0;
         if (k < lat && done_o) early = 1;
      end
      actv = observed();
      if (!expv[39]) begin
         actv[31:0] = '0;
         expv[31:0] = '0;
      end
      checks++;
      if (early || !done_o || actv !== expv) begin
         fails++;
         $display("FAIL %s op=%0d a=%h b=%h actual done=%b early=%b out=%h expected done=1 early=0 out=%h",
                  req, o, x, y, done_o, early, actv, expv);
      end
   endtask

   function automatic string req_of(int o);
      case (o)
         0, 1, 2: return "R3";
         3, 4, 5: return "R13";
         6, 7:    return "R4";
         8, 9:    return "R5";
         10:      return "R9";
         11:      return "R10";
         12, 13:  return "R11";
         14:      return "R12";
         default: return "R8";
      endcase
   endfunction

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 7))
         0: return 32'h0;
         1: return 32'hFFFF_FFFF;
         2: return 32'h8000_0000;
         3: return 32'h7FFF_FFFF;
         4: return 32'($urandom_range(0, 20));
         default: return $urandom();
      endcase
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!ended) begin
         fails++;
         $display("FAIL R2 watchdog actual=hang expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      checks++;
      if (observed() !== 40'd0 || done_o !== 1'b0 || busy_o !== 1'b0) begin
         fails++;
         $display("FAIL R1 actual out=%h done=%b busy=%b expected all zero", observed(), done_o, busy_o);
      end

      run_op("R2", 0, 5'd0, 32'd5, 32'd7, 0, 0, 0);
      run_op("R3", 0, 5'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0);
      run_op("R3", 0, 5'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, 0);
      run_op("R3", 1, 5'd0, 32'd1, 32'd1, 1, 0, 0);
      run_op("R3", 1, 5'd0, 32'hFFFF_FFFF, 32'd0, 1, 0, 0);
      run_op("R3", 2, 5'd0, 32'd0, 32'd1, 0, 0, 0);
      run_op("R3", 2, 5'd0, 32'h8000_0000, 32'd1, 0, 0, 0);
      run_op("R4", 6, 5'd0, 32'h0001_0000, 32'h0001_0000, 0, 0, 0);
      run_op("R4", 6, 5'd0, 32'hFFFF_FFFE, 32'd3, 0, 0, 0);
      run_op("R4", 7, 5'd0, 32'hFFFF_FFFE, 32'd3, 0, 0, 0);
      run_op("R5", 8, 5'd0, 32'hFFFF_FFF9, 32'd2, 0, 0, 0);
      run_op("R5", 8, 5'd0, 32'd7, 32'hFFFF_FFFE, 0, 0, 0);
      run_op("R5", 8, 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1, 0, 1);
      run_op("R5", 9, 5'd0, 32'hFFFF_FFFF, 32'd7, 0, 0, 0);
      run_op("R6", 8, 5'd0, 32'd12, 32'd0, 0, 0, 0);
      run_op("R6", 9, 5'd0, 32'd12, 32'd0, 0, 0, 0);
      run_op("R6", 9, 5'd0, 32'd10, 32'd3, 1, 0, 0);
      run_op("R7", 0, 5'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, 1);
      run_op("R7", 0, 5'd0, 32'd3, 32'd4, 0, 0, 1);
      run_op("R7", 6, 5'd0, 32'h0001_0000, 32'h0001_0000, 0, 0, 1);
      run_op("R7", 7, 5'd0, 32'h0001_0000, 32'h0001_0000, 0, 0, 1);
      run_op("R7", 8, 5'd0, 32'd9, 32'd0, 0, 0, 1);
      for (int s = 0; s < 16; s++) run_op("R8", 15, 5'(s), 32'hFFFF_FFFE, 32'd3, 0, 0, 0);
      run_op("R8", 15, 5'h00, 32'h1234_5678, 32'h1234_5678, 0, 1, 0);
      run_op("R8", 15, 5'h0D, 32'h1234_5678, 32'h1234_5678, 0, 0, 0);
      run_op("R9", 10, 5'd0, 32'h8000_0003, 32'd33, 0, 0, 0);
      run_op("R9", 10, 5'd1, 32'h8000_0003, 32'd4, 0, 0, 0);
      run_op("R9", 10, 5'd2, 32'h8000_0003, 32'd4, 0, 0, 0);
      run_op("R9", 10, 5'd3, 32'h8000_0003, 32'd4, 0, 0, 0);
      run_op("R9", 10, 5'd3, 32'h8000_0003, 32'd32, 0, 0, 0);
      for (int s = 0; s < 4; s++) run_op("R10", 11, 5'(s), 32'h1234_8081, 32'd0, 0, 0, 0);
      run_op("R11", 12, 5'd0, 32'd0, 32'd0, 0, 0, 0);
      run_op("R11", 12, 5'd0, 32'h0001_0100, 32'd0, 0, 0, 0);
      run_op("R11", 13, 5'd0, 32'h0001_0100, 32'd0, 0, 0, 0);
      run_op("R11", 13, 5'd0, 32'h8000_0000, 32'd0, 0, 0, 0);
      run_op("R11", 13, 5'd0, 32'd0, 32'd0, 0, 0, 0);
      run_op("R12", 14, 5'd0, 32'hAAAA_0000, 32'h0000_5555, 0, 1, 0);
      run_op("R12", 14, 5'd0, 32'hAAAA_0000, 32'h0000_5555, 0, 0, 0);
      run_op("R13", 3, 5'd0, 32'hF0F0_FFFF, 32'h0FF0_1234, 1, 1, 1);
      run_op("R13", 4, 5'd0, 32'hF0F0_0000, 32'h0FF0_1234, 1, 1, 1);
      run_op("R13", 5, 5'd0, 32'hF0F0_FFFF, 32'h0FF0_1234, 1, 1, 1);

      // R5: start while the divider is busy is ignored
      op = 4'd8; a = 32'd100; b = 32'd7; cin = 0; fin = 0; ove = 0; start = 1'b1;
      @(negedge clk);
      checks++;
      if (busy_o !== 1'b1) begin
         fails++;
         $display("FAIL R5 busy actual=%b expected=1", busy_o);
      end
      op = 4'd0; a = 32'd1; b = 32'd1;   // add offered while busy
      @(negedge clk);
      start = 1'b0;
      begin : overlap
         bit early = 0;
         for (int k = 3; k <= DIV_LAT; k++) begin
            if (done_o) early = 1;
            @(negedge clk);
         end
         checks++;
         if (early || !done_o || result_o !== 32'd14 || !wr_en_o) begin
            fails++;
            $display("FAIL R5 overlap actual done=%b early=%b res=%h expected done=1 early=0 res=0000000e",
                     done_o, early, result_o);
         end
      end
      @(negedge clk);
      checks++;
      if (done_o !== 1'b0) begin
         fails++;
         $display("FAIL R5 ignored start actual done=%b expected=0", done_o);
      end

      // random cross-check against the model
      for (int i = 0; i < 150; i++) begin
         int o = $urandom_range(0, 15);
         logic [4:0] s = 5'($urandom_range(0, 15));
         run_op(req_of(o), o, s, pick(), pick(), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule